// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block picks the three programmable settings of a clock synthesizer: the reference divider M, the feedback multiplier N and a 4-bit post-divider code. The caller gives a requested rate and the reference rate, both in kHz, and pulses a start input. The engine then walks a bounded search space and returns the setting whose output lands nearest to twice the requested rate. It also returns the remaining error, and a flag for the case where no legal setting exists.

All quotients are formed by one shared shift-subtract divider that yields one quotient bit per clock. The search therefore runs for a variable number of cycles. It ends with a one-cycle done pulse, and the published results are held until the next search completes. The search stops at once on the first exact hit. Otherwise it keeps the first candidate with the smallest error.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, busy_o, done_o and no_fit_o are 0 and ref_div_o, fb_mul_o, post_code_o and freq_err_o are all 0.
- R2: Post-divider codes 0..14 give ratios 1,2,3,4,5,6,8,10,12,16,12,16,20,24,32, and any higher code gives 1. The reverse map returns the first code among 0..13 whose ratio is not below the request, and 14 if there is none.
- R3: The search target T is 2×request. A padded VCO goal P is T + floor(T/50), and the VCO ceiling V is the larger of 2,064,000 and P. Codes are searched in increasing order, from revmap(clamp(floor(1,000,000/P))) up to revmap(clamp(ceil(V/P))), where clamp limits a value to 1..32.
- R4: For each code, M rises from 1. M ends the code when ref/M < 12,000, is skipped when ref/M > 38,000, and the code also ends after M = 255.
- R5: N runs from floor to ceiling of (T×ratio×M)/ref. A floor above 255 ends the code. N below 8 is skipped, and N above 255 ends that M. A reported N lies in 8..255 and a reported M in 1..255.
- R6: A candidate counts only when floor(ref×N/M) lies in 1,000,000..V. Its error is |floor((vco+floor(ratio/2))/ratio) − T|, and only a strictly smaller error replaces the best, so the first of equal errors wins.
- R7: A zero error ends the whole search at once, and the result is the first exact candidate in search order.
- R8: When no candidate counts, no_fit_o is 1, freq_err_o is all ones, ref_div_o is 255, fb_mul_o is 8 and post_code_o is 1.
- R9: done_o is high for exactly one cycle per search. busy_o is high from the cycle after start until done. The result outputs change only in the done cycle.
- R10: A start pulse while busy_o is high is ignored, and the running search keeps the request and reference captured at its own start.
- R11: Every division gives quotient q and remainder r with q×d + r = n and r < d for a nonzero divisor d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| req_khz_i | input | W | Requested rate in kHz |
| ref_khz_i | input | W | Reference rate in kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| no_fit_o | output | 1 | No candidate was found |
| ref_div_o | output | MW | Chosen M |
| fb_mul_o | output | NW | Chosen N |
| post_code_o | output | 4 | Chosen post-divider code |
| freq_err_o | output | W | Error of the chosen setting |

## Verification
Search length depends on the inputs. Every division costs W stepping cycles plus one issue cycle, so the only fixed timing is this: busy_o rises one cycle after start, and the results are valid in the same cycle as the done pulse. The bench drives start on a falling edge and then polls done_o on every falling edge within a bounded window. It compares all outputs in that cycle against a behavioural model of the search order, and it checks again one cycle later that done has dropped. Hold, ignored-start and mid-search reset checks are then sampled a fixed number of cycles after their stimulus.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    localparam int CODE_W  = 4;
    localparam int RATIO_W = 6;
    localparam int LAST_CODE = 14;

    typedef enum logic [3:0] {
        S_IDLE, S_PAD, S_HIGH, S_LOW, S_CODE, S_MSTEP, S_CMP,
        S_NFLOOR, S_NSTEP, S_VCO, S_ROUND, S_FIN
    } srch_state_e;

    // code -> post-divider ratio; the sequence is not monotonic
    function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
        case (c)
            4'd0:  code_ratio = 6'd1;
            4'd1:  code_ratio = 6'd2;
            4'd2:  code_ratio = 6'd3;
            4'd3:  code_ratio = 6'd4;
            4'd4:  code_ratio = 6'd5;
            4'd5:  code_ratio = 6'd6;
            4'd6:  code_ratio = 6'd8;
            4'd7:  code_ratio = 6'd10;
            4'd8:  code_ratio = 6'd12;
            4'd9:  code_ratio = 6'd16;
            4'd10: code_ratio = 6'd12;
            4'd11: code_ratio = 6'd16;
            4'd12: code_ratio = 6'd20;
            4'd13: code_ratio = 6'd24;
            4'd14: code_ratio = 6'd32;
            default: code_ratio = 6'd1;
        endcase
    endfunction

endpackage

// File: rtl/pll_ratio_lut.sv
module pll_ratio_lut
    import pll_search_pkg::*;
(
    input  logic [CODE_W-1:0]  code_i,
    output logic [RATIO_W-1:0] ratio_o
);
    assign ratio_o = code_ratio(code_i);
endmodule

// File: rtl/pll_code_map.sv
module pll_code_map
    import pll_search_pkg::*;
#(
    parameter int W     = 32,
    parameter int R_MIN = 1,
    parameter int R_MAX = 32
) (
    input  logic [W-1:0]      ratio_i,
    output logic [CODE_W-1:0] code_o
);
    logic [W-1:0] clamped;

    always_comb begin
        if (ratio_i < W'(R_MIN))      clamped = W'(R_MIN);
        else if (ratio_i > W'(R_MAX)) clamped = W'(R_MAX);
        else                          clamped = ratio_i;
        // scan downward so the lowest qualifying code wins
        code_o = CODE_W'(LAST_CODE);
        for (int c = LAST_CODE - 1; c >= 0; c--) begin
            if (W'(code_ratio(CODE_W'(c))) >= clamped) code_o = CODE_W'(c);
        end
    end
endmodule

// File: rtl/pll_search_div.sv
module pll_search_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         valid_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             busy;
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     acc;
        logic [W-1:0]     quo;
        logic [W-1:0]     den;
        logic [W-1:0]     num;
    } div_t;

    div_t q, d;
    logic [W:0] shifted;
    logic       fits;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        shifted = {q.acc, q.quo[W-1]};
        fits    = shifted >= {1'b0, q.den};
        if (start_i && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(W);
            d.acc  = '0;
            d.quo  = num_i;
            d.num  = num_i;
            d.den  = den_i;
        end else if (q.busy) begin
            d.acc = fits ? W'(shifted - {1'b0, q.den}) : shifted[W-1:0];
            d.quo = {q.quo[W-2:0], fits};
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy  = 1'b0;
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid_o = q.valid;
    assign quo_o   = q.quo;
    assign rem_o   = q.acc;

    assert_div_exact_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && q.den != '0) |->
        (q.acc < q.den &&
         ({{W{1'b0}}, q.quo} * {{W{1'b0}}, q.den} + {{W{1'b0}}, q.acc}) == {{W{1'b0}}, q.num}));

    assert_div_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
    import pll_search_pkg::*;
#(
    parameter int W       = 32,
    parameter int MW      = 8,
    parameter int NW      = 8,
    parameter int VCO_MIN = 1000000,
    parameter int VCO_MAX = 2064000,
    parameter int CMP_MIN = 12000,
    parameter int CMP_MAX = 38000,
    parameter int M_MIN   = 1,
    parameter int M_MAX   = 255,
    parameter int N_MIN   = 8,
    parameter int N_MAX   = 255,
    parameter int R_MIN   = 1,
    parameter int R_MAX   = 32,
    parameter int PAD_DIV = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [W-1:0]      req_khz_i,
    input  logic [W-1:0]      ref_khz_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              no_fit_o,
    output logic [MW-1:0]     ref_div_o,
    output logic [NW-1:0]     fb_mul_o,
    output logic [CODE_W-1:0] post_code_o,
    output logic [W-1:0]      freq_err_o
);
    localparam logic [W-1:0] VMIN_L = W'(VCO_MIN);
    localparam logic [W-1:0] VMAX_L = W'(VCO_MAX);

    typedef struct packed {
        srch_state_e         st;
        logic                go;
        logic [W-1:0]        dnum;
        logic [W-1:0]        dden;
        logic [W-1:0]        refk;
        logic [W-1:0]        tgt;
        logic [W-1:0]        pad;
        logic [W-1:0]        vceil;
        logic [W-1:0]        vtgt;
        logic [W-1:0]        n;
        logic [W-1:0]        n_top;
        logic [CODE_W-1:0]   hi;
        logic [CODE_W-1:0]   pl;
        logic [RATIO_W-1:0]  ratio;
        logic [MW:0]         m;
        logic [MW-1:0]       bm;
        logic [NW-1:0]       bn;
        logic [CODE_W-1:0]   bpl;
        logic [W-1:0]        berr;
        logic [MW-1:0]       o_m;
        logic [NW-1:0]       o_n;
        logic [CODE_W-1:0]   o_pl;
        logic [W-1:0]        o_err;
        logic                o_nofit;
        logic                done;
    } srch_t;

    srch_t q, d;

    logic               dv_valid;
    logic [W-1:0]       dv_quo, dv_rem;
    logic [CODE_W-1:0]  mapped_code;
    logic [RATIO_W-1:0] cur_ratio;
    logic [W-1:0]       pad_n, vceil_n, delta;

    pll_search_div #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .start_i(q.go),
        .num_i(q.dnum), .den_i(q.dden),
        .valid_o(dv_valid), .quo_o(dv_quo), .rem_o(dv_rem)
    );

    pll_code_map #(.W(W), .R_MIN(R_MIN), .R_MAX(R_MAX)) u_map (
        .ratio_i(dv_quo), .code_o(mapped_code)
    );

    pll_ratio_lut u_lut (.code_i(q.pl), .ratio_o(cur_ratio));

    always_comb begin
        d       = q;
        d.go    = 1'b0;
        d.done  = 1'b0;
        pad_n   = q.tgt + dv_quo;
        vceil_n = (pad_n > VMAX_L) ? pad_n : VMAX_L;
        delta   = (dv_quo >= q.tgt) ? dv_quo - q.tgt : q.tgt - dv_quo;
        case (q.st)
            S_IDLE: if (start_i) begin
                d.tgt  = req_khz_i << 1;
                d.refk = ref_khz_i;
                d.berr = '1;
                d.bm   = MW'(M_MAX);
                d.bn   = NW'(N_MIN);
                d.bpl  = CODE_W'(R_MIN);
                d.go   = 1'b1;
                d.dnum = req_khz_i << 1;
                d.dden = W'(PAD_DIV);
                d.st   = S_PAD;
            end
            S_PAD: if (dv_valid) begin
                d.pad   = pad_n;
                d.vceil = vceil_n;
                d.go    = 1'b1;
                d.dnum  = vceil_n + pad_n - 1'b1;
                d.dden  = pad_n;
                d.st    = S_HIGH;
            end
            S_HIGH: if (dv_valid) begin
                d.hi   = mapped_code;
                d.go   = 1'b1;
                d.dnum = VMIN_L;
                d.dden = q.pad;
                d.st   = S_LOW;
            end
            S_LOW: if (dv_valid) begin
                d.pl = mapped_code;
                d.st = S_CODE;
            end
            S_CODE: begin
                if (q.pl > q.hi) d.st = S_FIN;
                else begin
                    d.ratio = cur_ratio;
                    d.vtgt  = q.tgt * W'(cur_ratio);
                    d.m     = (MW+1)'(M_MIN);
                    d.st    = S_MSTEP;
                end
            end
            S_MSTEP: begin
                if (q.m > (MW+1)'(M_MAX)) begin
                    d.pl = q.pl + 1'b1;
                    d.st = S_CODE;
                end else begin
                    d.go   = 1'b1;
                    d.dnum = q.refk;
                    d.dden = W'(q.m);
                    d.st   = S_CMP;
                end
            end
            S_CMP: if (dv_valid) begin
                if (dv_quo < W'(CMP_MIN)) begin
                    d.pl = q.pl + 1'b1;
                    d.st = S_CODE;
                end else if (dv_quo > W'(CMP_MAX)) begin
                    d.m  = q.m + 1'b1;
                    d.st = S_MSTEP;
                end else begin
                    d.go   = 1'b1;
                    d.dnum = q.vtgt * W'(q.m);
                    d.dden = q.refk;
                    d.st   = S_NFLOOR;
                end
            end
            S_NFLOOR: if (dv_valid) begin
                d.n     = dv_quo;
                d.n_top = dv_quo + W'(dv_rem != '0);
                if (dv_quo > W'(N_MAX)) begin
                    d.pl = q.pl + 1'b1;
                    d.st = S_CODE;
                end else d.st = S_NSTEP;
            end
            S_NSTEP: begin
                if (q.n > q.n_top || q.n > W'(N_MAX)) begin
                    d.m  = q.m + 1'b1;
                    d.st = S_MSTEP;
                end else if (q.n < W'(N_MIN)) begin
                    d.n = q.n + 1'b1;
                end else begin
                    d.go   = 1'b1;
                    d.dnum = q.refk * q.n;
                    d.dden = W'(q.m);
                    d.st   = S_VCO;
                end
            end
            S_VCO: if (dv_valid) begin
                if (dv_quo >= VMIN_L && dv_quo <= q.vceil) begin
                    d.go   = 1'b1;
                    d.dnum = dv_quo + W'(q.ratio >> 1);
                    d.dden = W'(q.ratio);
                    d.st   = S_ROUND;
                end else begin
                    d.n  = q.n + 1'b1;
                    d.st = S_NSTEP;
                end
            end
            S_ROUND: if (dv_valid) begin
                d.n  = q.n + 1'b1;
                d.st = S_NSTEP;
                if (delta < q.berr) begin
                    d.berr = delta;
                    d.bm   = q.m[MW-1:0];
                    d.bn   = q.n[NW-1:0];
                    d.bpl  = q.pl;
                    if (delta == '0) d.st = S_FIN;
                end
            end
            S_FIN: begin
                d.o_m     = q.bm;
                d.o_n     = q.bn;
                d.o_pl    = q.bpl;
                d.o_err   = q.berr;
                d.o_nofit = (q.berr == '1);
                d.done    = 1'b1;
                d.st      = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o      = (q.st != S_IDLE);
    assign done_o      = q.done;
    assign no_fit_o    = q.o_nofit;
    assign ref_div_o   = q.o_m;
    assign fb_mul_o    = q.o_n;
    assign post_code_o = q.o_pl;
    assign freq_err_o  = q.o_err;

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ref_div_o, fb_mul_o, post_code_o, freq_err_o, no_fit_o}) |-> done_o);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (q.tgt == $past(q.tgt) && q.refk == $past(q.refk)));

    assert_legal_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !no_fit_o) |->
        (fb_mul_o >= NW'(N_MIN) && fb_mul_o <= NW'(N_MAX) &&
         ref_div_o >= MW'(M_MIN) && ref_div_o <= MW'(M_MAX)));

    assert_nofit_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && no_fit_o) |->
        (ref_div_o == MW'(M_MAX) && fb_mul_o == NW'(N_MIN) &&
         post_code_o == CODE_W'(R_MIN) && freq_err_o == '1));

    assert_exact_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_ROUND && dv_valid && delta == '0 && q.berr != '0) |=> (q.st == S_FIN));
endmodule

// File: tb/pll_coef_search_bench.sv
module pll_coef_search_bench;
    localparam int NV = 8;
    localparam logic [31:0] V_REQ [NV] = '{32'd72000, 32'd108000, 32'd252000, 32'd500000,
                                           32'd852000, 32'd396000, 32'd1100000, 32'd500000};
    localparam logic [31:0] V_REF [NV] = '{32'd38400, 32'd19200, 32'd12000, 32'd13000,
                                           32'd38400, 32'd19200, 32'd38400, 32'd10000};
    localparam int WAIT_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req = '0, rfk = '0;
    logic        busy, done, nofit;
    logic [7:0]  mo, no;
    logic [3:0]  plo;
    logic [31:0] erro;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    pll_coef_search u_pll_coef_search (
        .clk(clk), .rst_n(rst_n), .start_i(start), .req_khz_i(req), .ref_khz_i(rfk),
        .busy_o(busy), .done_o(done), .no_fit_o(nofit), .ref_div_o(mo),
        .fb_mul_o(no), .post_code_o(plo), .freq_err_o(erro)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    function automatic logic [5:0] ratio_of(input int c);
        case (c)
            0: return 1;   1: return 2;   2: return 3;   3: return 4;
            4: return 5;   5: return 6;   6: return 8;   7: return 10;
            8: return 12;  9: return 16;  10: return 12; 11: return 16;
            12: return 20; 13: return 24; 14: return 32;
            default: return 1;
        endcase
    endfunction

    function automatic int code_for(input logic [31:0] r);
        logic [31:0] c;
        c = (r < 1) ? 32'd1 : (r > 32) ? 32'd32 : r;
        for (int k = 0; k < 14; k++) if (32'(ratio_of(k)) >= c) return k;
        return 14;
    endfunction

    // behavioural model of the search order (R3..R8)
    function automatic void model(input logic [31:0] rq, rf,
                                  output logic [7:0] em, output logic [7:0] en,
                                  output logic [3:0] ep, output logic [31:0] ee);
        logic [31:0] tgt, pad, vc, vt, uf, pr, nf, nt, vco, lw, dl, best;
        logic [31:0] rt;
        int lo, hi;
        bit stop;
        tgt  = rq * 2;
        pad  = tgt + tgt / 50;
        vc   = (pad > 32'd2064000) ? pad : 32'd2064000;
        hi   = code_for((vc + pad - 1) / pad);
        lo   = code_for(32'd1000000 / pad);
        best = '1; em = 8'd255; en = 8'd8; ep = 4'd1; stop = 0;
        for (int p = lo; p <= hi && !stop; p++) begin
            rt = 32'(ratio_of(p));
            vt = tgt * rt;
            for (int m = 1; m <= 255 && !stop; m++) begin
                uf = rf / 32'(m);
                if (uf < 32'd12000) break;
                if (uf > 32'd38000) continue;
                pr = vt * 32'(m);
                nf = pr / rf;
                nt = (pr + rf - 1) / rf;
                if (nf > 32'd255) break;
                for (int n = int'(nf); n <= int'(nt) && !stop; n++) begin
                    if (n < 8) continue;
                    if (n > 255) break;
                    vco = (rf * 32'(n)) / 32'(m);
                    if (vco >= 32'd1000000 && vco <= vc) begin
                        lw = (vco + rt / 2) / rt;
                        dl = (lw >= tgt) ? lw - tgt : tgt - lw;
                        if (dl < best) begin
                            best = dl; em = 8'(m); en = 8'(n); ep = 4'(p);
                            if (dl == 0) stop = 1;
                        end
                    end
                end
            end
        end
        ee = best;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic launch(input logic [31:0] r, f);
        @(negedge clk);
        req = r; rfk = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int k = 0; k < WAIT_LIMIT && !seen; k++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
    endtask

    task automatic check_result(input logic [31:0] r, f, input string tag);
        logic [7:0] em, en; logic [3:0] ep; logic [31:0] ee;
        model(r, f, em, en, ep, ee);
        chk("R4", {tag, " M"}, 32'(mo), 32'(em));
        chk("R5", {tag, " N"}, 32'(no), 32'(en));
        chk("R3", {tag, " code"}, 32'(plo), 32'(ep));
        chk("R6", {tag, " error"}, erro, ee);
        chk("R8", {tag, " no-fit flag"}, 32'(nofit), 32'(ee == '1));
    endtask

    initial begin
        bit seen;
        logic [7:0] hm, hn; logic [3:0] hp; logic [31:0] he;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "results", {mo, no, plo, 4'(nofit)}, 0);
        chk("R1", "error", erro, 0);

        for (int i = 0; i < NV; i++) begin
            launch(V_REQ[i], V_REF[i]);
            chk("R9", "busy after start", 32'(busy), 1);
            wait_done(seen);
            chk("R9", "done seen", 32'(seen), 1);
            if (seen) check_result(V_REQ[i], V_REF[i], $sformatf("vec%0d", i));
            @(negedge clk);
            chk("R9", "done one cycle", 32'(done), 0);
        end

        // R7: exact hit stops at first exact candidate, code 6 (ratio 8, R2)
        launch(32'd72000, 32'd38400);
        wait_done(seen);
        chk("R7", "exact error", erro, 0);
        chk("R2", "exact code", 32'(plo), 6);
        chk("R7", "exact M", 32'(mo), 2);
        chk("R7", "exact N", 32'(no), 60);

        // R8 explicit defaults when reference too slow
        launch(32'd500000, 32'd10000);
        wait_done(seen);
        chk("R8", "nofit", 32'(nofit), 1);
        chk("R8", "default M", 32'(mo), 255);
        chk("R8", "default N", 32'(no), 8);
        chk("R8", "default code", 32'(plo), 1);

        // R11: a non-exact result needs every quotient right
        launch(32'd1100000, 32'd38400);
        wait_done(seen);
        chk("R11", "fine error", erro, 1600);

        // R9 hold: outputs stay after done
        hm = mo; hn = no; hp = plo; he = erro;
        repeat (20) @(negedge clk);
        chk("R9", "hold", {mo, no, plo, he}, {hm, hn, hp, erro});

        // R10: second start while busy is ignored
        launch(32'd252000, 32'd12000);
        repeat (10) @(negedge clk);
        req = 32'd852000; rfk = 32'd38400; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        check_result(32'd252000, 32'd12000, "R10 busy-start");
        @(negedge clk);
        chk("R10", "idle after single search", 32'(busy), 0);

        // R1: reset in mid-search returns to idle
        launch(32'd396000, 32'd19200);
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", 32'(busy), 0);
        chk("R1", "results after reset", {mo, no, plo, 4'(nofit)}, 0);

        finish_run();
    end
endmodule